// File: doc/BRIEF.md
# Register-Exchange Hard-Decision Viterbi Decoder

This block decodes a stream protected by the four-state, rate-1/2 convolutional code with generators 7 and 5 (octal). Each received symbol is a pair of hard-decided bits presented with a valid strobe. For every accepted symbol the block updates one path metric per trellis state by add-compare-select on Hamming distances. It also updates one survivor shift register per state by copying the register of the winning predecessor and appending that branch's input bit.

No trace-back pass is needed. Once the survivor registers have filled, every accepted symbol produces one decoded bit. That bit is the oldest entry of the survivor register that belongs to the state with the smallest path metric. The decision delay is therefore the survivor length (five constraint lengths, fifteen symbols by default) plus one register stage. Path metrics are kept bounded: when every metric has reached a threshold, the minimum is subtracted from all of them.

Top module: `rxv_decoder`

## Requirements
- R1: `in_sym[1]` carries the parity bit of generator 7 and `in_sym[0]` the parity bit of generator 5. The trellis state is {previous input, input before that}. When the encoder starts from the all-zero state and the channel adds no errors, the decoded output equals the source bits in order.
- R2: The branch metric is the Hamming distance between `in_sym` and the branch word. Each state keeps the smaller of its two candidate sums. On equal sums it keeps the predecessor whose least significant state bit is 0.
- R3: On each accepted symbol, every state's survivor register becomes its chosen predecessor's register shifted by one place, with the input bit of the branch into that state appended as the newest bit. The decoded bit is the oldest bit.
- R4: The output is read from the state with the smallest path metric. When several states share that minimum, the lowest-numbered state is used.
- R5: `out_valid` pulses for exactly one cycle, on the cycle after each accepted symbol, once at least SURV_LEN symbols have been accepted since reset. The first pulse carries the decision for the first symbol.
- R6: After reset, state 0 starts with metric 0 and every other state starts with metric INIT_PEN.
- R7: Whenever all updated metrics are at or above NORM_THR, the smallest of them is subtracted from every metric. This never changes a decision, and it keeps every metric bounded over arbitrarily long streams.
- R8: While `in_valid` is low, `in_sym` is ignored: no metric, survivor or output changes and `out_valid` stays low.
- R9: An asynchronous active-low reset in the middle of a stream restores the initial metrics and restarts the fill count. No output appears until SURV_LEN new symbols have been accepted.
- R10: A single flipped channel bit, with flips at least 17 symbols apart, is corrected, and the output still equals the source bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_sym` for one symbol per cycle |
| in_sym | input | 2 | Hard-decided received pair: bit 1 from generator 7, bit 0 from generator 5 |
| out_valid | output | 1 | One-cycle pulse marking a decoded bit |
| out_bit | output | 1 | Decoded bit, meaningful while `out_valid` is high |

## Verification
A bound checker enforces the cycle-level rules on every clock. Outputs may appear only after an accepted symbol and only once the fill count has reached the survivor length. Idle cycles must leave the metrics and the best-state pointer untouched. Metrics must stay under their normalisation bound with the minimum below the threshold, and the best-state pointer must always name the lowest-numbered minimum-metric state. Whether the decoded bits are right can only be shown by the bench's scenarios. These drive clean, sparsely corrupted and random noisy streams with gaps and a mid-stream reset, and compare each output against an unnormalised software trellis and, where known, against the source bits.

// File: rtl/rxv_pkg.sv
package rxv_pkg;

   typedef logic [1:0] sym_t;

   // Parity pair produced by the encoder taps for one register word:
   // bit 1 from gen_a, bit 0 from gen_b.
   function automatic logic [1:0] branch_pair(input logic [31:0] taps,
                                              input logic [31:0] gen_a,
                                              input logic [31:0] gen_b);
      return {^(taps & gen_a), ^(taps & gen_b)};
   endfunction

   // Predecessor of state st whose dropped (oldest) bit equals hi.
   function automatic int pred_state(input int st, input int hi, input int sw);
      return ((st << 1) | hi) & ((1 << sw) - 1);
   endfunction

endpackage

// File: rtl/rxv_acs.sv
module rxv_acs
   import rxv_pkg::*;
#(
   parameter int K     = 3,
   parameter int GEN_A = 7,
   parameter int GEN_B = 5,
   parameter int PM_W  = 6,
   parameter int STATE = 0
) (
   input  sym_t            rx,
   input  logic [PM_W-1:0] pm_p0,
   input  logic [PM_W-1:0] pm_p1,
   output logic [PM_W-1:0] pm_next,
   output logic            pick_hi
);

   localparam int SW   = K - 1;
   localparam int U    = (STATE >> (SW - 1)) & 1;
   localparam int P0   = pred_state(STATE, 0, SW);
   localparam int P1   = pred_state(STATE, 1, SW);
   localparam int TAP0 = (U << SW) | P0;
   localparam int TAP1 = (U << SW) | P1;
   localparam logic [1:0] CW0 = branch_pair(32'(TAP0), 32'(GEN_A), 32'(GEN_B));
   localparam logic [1:0] CW1 = branch_pair(32'(TAP1), 32'(GEN_A), 32'(GEN_B));

   logic [1:0]      dist0, dist1;
   logic [PM_W-1:0] cand0, cand1;

   assign dist0 = {1'b0, rx[1] ^ CW0[1]} + {1'b0, rx[0] ^ CW0[0]};
   assign dist1 = {1'b0, rx[1] ^ CW1[1]} + {1'b0, rx[0] ^ CW1[0]};

   assign cand0 = pm_p0 + PM_W'(dist0);
   assign cand1 = pm_p1 + PM_W'(dist1);

   // strict compare: ties stay with the predecessor whose low bit is 0
   assign pick_hi = (cand1 < cand0);
   assign pm_next = pick_hi ? cand1 : cand0;

endmodule

// File: rtl/rxv_minsel.sv
module rxv_minsel #(
   parameter int N  = 4,
   parameter int W  = 6,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0][W-1:0] vals,
   output logic [W-1:0]        min_val,
   output logic [IW-1:0]       min_idx
);

   always_comb begin
      min_val = vals[0];
      min_idx = '0;
      for (int i = 1; i < N; i++) begin
         if (vals[i] < min_val) begin
            min_val = vals[i];
            min_idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/rxv_surv.sv
module rxv_surv
   import rxv_pkg::*;
#(
   parameter int K        = 3,
   parameter int SURV_LEN = 15,
   parameter int NS       = 1 << (K - 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [NS-1:0] pick_hi,
   output logic [NS-1:0] oldest
);

   localparam int SW = K - 1;

   logic [NS-1:0][SURV_LEN-1:0] sr_all;

   for (genvar s = 0; s < NS; s++) begin : g_state
      localparam int   P0 = pred_state(s, 0, SW);
      localparam int   P1 = pred_state(s, 1, SW);
      localparam logic U  = 1'((s >> (SW - 1)) & 1);

      logic [SURV_LEN-1:0] sr_q;
      logic [SURV_LEN-2:0] keep;

      assign keep = pick_hi[s] ? sr_all[P1][SURV_LEN-2:0] : sr_all[P0][SURV_LEN-2:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    sr_q <= '0;
         else if (step) sr_q <= {keep, U};
      end

      assign sr_all[s] = sr_q;
      assign oldest[s] = sr_q[SURV_LEN-1];
   end

endmodule

// File: rtl/rxv_decoder.sv
module rxv_decoder
   import rxv_pkg::*;
#(
   parameter int K        = 3,
   parameter int GEN_A    = 7,
   parameter int GEN_B    = 5,
   parameter int SURV_LEN = 5 * K,
   parameter int PM_W     = 6,
   parameter int INIT_PEN = 8,
   parameter int NORM_THR = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [1:0] in_sym,
   output logic       out_valid,
   output logic       out_bit
);

   localparam int NS    = 1 << (K - 1);
   localparam int SW    = K - 1;
   localparam int CNT_W = $clog2(SURV_LEN + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(SURV_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SURV_LEN - 1);

   // elaboration-time parameter checks
   if (K < 3) begin : g_bad_k
      $error("rxv_decoder: K must be at least 3");
   end
   if (GEN_A >= (1 << K) || GEN_A < (1 << (K - 1)) ||
       GEN_B >= (1 << K) || GEN_B < (1 << (K - 1))) begin : g_bad_gen
      $error("rxv_decoder: generators must be K bits wide with the newest tap set");
   end
   if (SURV_LEN < 2) begin : g_bad_len
      $error("rxv_decoder: SURV_LEN must be at least 2");
   end
   if (NORM_THR < 1 || NORM_THR + INIT_PEN + 4 >= (1 << PM_W)) begin : g_bad_pm
      $error("rxv_decoder: PM_W too narrow for NORM_THR and INIT_PEN");
   end

   logic [NS-1:0][PM_W-1:0] pm_q, pm_raw, pm_d;
   logic [NS-1:0]           pick_hi;
   logic [NS-1:0]           oldest;
   logic [PM_W-1:0]         raw_min;
   logic [SW-1:0]           raw_best, best_q;
   logic                    norm;
   logic [CNT_W-1:0]        fill_q;
   logic                    out_vld_q;

   // add-compare-select, one unit per state
   for (genvar s = 0; s < NS; s++) begin : g_acs
      localparam int P0 = pred_state(s, 0, SW);
      localparam int P1 = pred_state(s, 1, SW);
      rxv_acs #(
         .K(K), .GEN_A(GEN_A), .GEN_B(GEN_B), .PM_W(PM_W), .STATE(s)
      ) u_acs (
         .rx      (in_sym),
         .pm_p0   (pm_q[P0]),
         .pm_p1   (pm_q[P1]),
         .pm_next (pm_raw[s]),
         .pick_hi (pick_hi[s])
      );
   end

   // minimum of the updated metrics: drives normalisation and best state
   rxv_minsel #(.N(NS), .W(PM_W), .IW(SW)) u_min (
      .vals    (pm_raw),
      .min_val (raw_min),
      .min_idx (raw_best)
   );

   assign norm = (raw_min >= PM_W'(NORM_THR));

   for (genvar s = 0; s < NS; s++) begin : g_norm
      assign pm_d[s] = norm ? (pm_raw[s] - raw_min) : pm_raw[s];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NS; s++)
            pm_q[s] <= (s == 0) ? '0 : PM_W'(INIT_PEN);
         best_q <= '0;
      end else if (in_valid) begin
         pm_q   <= pm_d;
         best_q <= raw_best;
      end
   end

   rxv_surv #(.K(K), .SURV_LEN(SURV_LEN), .NS(NS)) u_surv (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (in_valid),
      .pick_hi (pick_hi),
      .oldest  (oldest)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q    <= '0;
         out_vld_q <= 1'b0;
      end else begin
         if (in_valid && fill_q != FULL) fill_q <= fill_q + 1'b1;
         out_vld_q <= in_valid && (fill_q >= LAST);
      end
   end

   assign out_valid = out_vld_q;
   assign out_bit   = oldest[best_q];

endmodule

// File: rtl/rxv_decoder_chk.sv
module rxv_decoder_chk #(
   parameter int K        = 3,
   parameter int SURV_LEN = 15,
   parameter int PM_W     = 6,
   parameter int INIT_PEN = 8,
   parameter int NORM_THR = 32,
   parameter int NS       = 1 << (K - 1),
   parameter int SW       = K - 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    out_valid,
   input logic [NS-1:0][PM_W-1:0] pm_q,
   input logic [SW-1:0]           best_q
);

   localparam int CNT_W = $clog2(SURV_LEN + 1);

   logic [CNT_W-1:0] seen_q;
   logic [PM_W-1:0]  pm_min, pm_max;
   logic             best_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          seen_q <= '0;
      else if (in_valid && seen_q != CNT_W'(SURV_LEN))     seen_q <= seen_q + 1'b1;
   end

   always_comb begin
      pm_min = pm_q[0];
      pm_max = pm_q[0];
      for (int i = 1; i < NS; i++) begin
         if (pm_q[i] < pm_min) pm_min = pm_q[i];
         if (pm_q[i] > pm_max) pm_max = pm_q[i];
      end
      best_ok = (pm_q[best_q] == pm_min);
      for (int i = 0; i < NS; i++)
         if (i < int'(best_q) && pm_q[i] == pm_min) best_ok = 1'b0;
   end

   // R5
   out_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   // R5
   out_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(seen_q) >= SURV_LEN));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(pm_q) && $stable(best_q) && !out_valid));

   // R7
   metric_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pm_max) <= NORM_THR + INIT_PEN + 2);

   // R7
   metric_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pm_min) < NORM_THR);

   // R4
   best_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      best_ok);

endmodule

bind rxv_decoder rxv_decoder_chk #(
   .K(K), .SURV_LEN(SURV_LEN), .PM_W(PM_W), .INIT_PEN(INIT_PEN), .NORM_THR(NORM_THR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .pm_q      (pm_q),
   .best_q    (best_q)
);

// File: tb/tb_rxv_decoder.sv
module tb_rxv_decoder;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int L = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [1:0] in_sym = 2'b00;
   logic       out_valid, out_bit;

   always #2.5 clk = ~clk;

   rxv_decoder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
      .out_valid(out_valid), .out_bit(out_bit)
   );

   typedef struct { bit e; bit h; bit s; } item_t;

   item_t      exp_q[$];
   bit         pend_src[$];
   bit         pend_has[$];
   int         checks = 0, fails = 0, out_count = 0;
   string      cur_req = "R6";
   bit         done = 0;

   int         mpm[4];
   logic [L-1:0] msr[4];
   int         mfill;
   logic [1:0] enc_st;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic int cost(input int p, input bit u, input logic [1:0] rx);
      bit g7, g5;
      g7 = u ^ bit'((p >> 1) & 1) ^ bit'(p & 1);
      g5 = u ^ bit'(p & 1);
      return int'(rx[1] ^ g7) + int'(rx[0] ^ g5);
   endfunction

   task automatic model_reset();
      mpm[0] = 0; mpm[1] = 8; mpm[2] = 8; mpm[3] = 8;
      for (int s = 0; s < 4; s++) msr[s] = '0;
      mfill = 0;
      enc_st = 2'b00;
      exp_q.delete();
      pend_src.delete();
      pend_has.delete();
   endtask

   // unnormalised reference trellis built from R2, R3, R4, R6
   task automatic model_step(input logic [1:0] rx);
      int npm[4];
      logic [L-1:0] nsr[4];
      int best;
      item_t it;
      for (int s = 0; s < 4; s++) begin
         int p0, p1, a0, a1;
         bit u;
         u  = bit'((s >> 1) & 1);
         p0 = (s & 1) * 2;
         p1 = p0 + 1;
         a0 = mpm[p0] + cost(p0, u, rx);
         a1 = mpm[p1] + cost(p1, u, rx);
         if (a1 < a0) begin npm[s] = a1; nsr[s] = {msr[p1][L-2:0], u}; end
         else         begin npm[s] = a0; nsr[s] = {msr[p0][L-2:0], u}; end
      end
      for (int s = 0; s < 4; s++) begin mpm[s] = npm[s]; msr[s] = nsr[s]; end
      mfill++;
      best = 0;
      for (int s = 1; s < 4; s++) if (npm[s] < npm[best]) best = s;
      if (mfill >= L) begin
         it.e = msr[best][L-1];
         it.h = pend_has.pop_front();
         it.s = pend_src.pop_front();
         exp_q.push_back(it);
      end
   endtask

   task automatic encode(input bit u, output logic [1:0] cw);
      cw = {u ^ enc_st[1] ^ enc_st[0], u ^ enc_st[0]};
      enc_st = {u, enc_st[1]};
   endtask

   task automatic send(input logic [1:0] rx, input bit has_src, input bit src, input int gap);
      @(negedge clk);
      in_valid = 1'b1;
      in_sym   = rx;
      pend_src.push_back(src);
      pend_has.push_back(has_src);
      model_step(rx);
      repeat (gap) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sym   = 2'($urandom);   // R8: garbage while idle
      end
   endtask

   task automatic send_info(input bit u, input logic [1:0] flip, input int gap);
      logic [1:0] cw;
      encode(u, cw);
      send(cw ^ flip, 1'b1, u, gap);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_sym   = 2'($urandom);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R9", "out_valid during reset", int'(out_valid), 0);
      rst_n     = 1'b1;
      out_count = 0;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         out_count++;
         if (exp_q.size() == 0) begin
            check(1'b0, cur_req, "out_valid with nothing expected", 1, 0);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            check(out_bit == it.e, cur_req, "decoded bit vs trellis model", int'(out_bit), int'(it.e));
            if (it.h)
               check(out_bit == it.s, cur_req, "decoded bit vs source bit", int'(out_bit), int'(it.s));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R6", "out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;

      // Scenario A: clean stream, back to back (R1 R3 R5)
      do_reset();
      cur_req = "R1 R3";
      for (int i = 0; i < L - 1; i++) send_info(1'($urandom), 2'b00, 0);
      idle(2);
      check(out_count == 0, "R5", "outputs before SURV_LEN symbols", out_count, 0);
      send_info(1'($urandom), 2'b00, 0);
      idle(2);
      check(out_count == 1, "R5", "outputs after SURV_LEN symbols", out_count, 1);
      for (int i = 0; i < 45; i++) send_info(1'($urandom), 2'b00, 0);
      idle(3);
      check(exp_q.size() == 0, "R5", "pending outputs after clean run", exp_q.size(), 0);
      check(out_count == 46, "R5", "one output per symbol", out_count, 46);

      // Scenario B: gaps with garbage on in_sym (R8)
      do_reset();
      cur_req = "R8";
      for (int i = 0; i < 40; i++) send_info(1'($urandom), 2'b00, 1 + ($urandom % 3));
      idle(3);
      check(exp_q.size() == 0, "R8", "pending outputs after gapped run", exp_q.size(), 0);
      check(out_count == 26, "R8", "outputs count with gaps", out_count, 26);

      // Scenario C: isolated single-bit errors (R10)
      do_reset();
      cur_req = "R10";
      for (int i = 0; i < 300; i++) begin
         logic [1:0] fl;
         fl = (i % 17 == 5) ? ((i % 2 == 0) ? 2'b01 : 2'b10) : 2'b00;
         send_info(1'($urandom), fl, 0);
      end
      idle(3);
      check(exp_q.size() == 0, "R10", "pending outputs after error run", exp_q.size(), 0);

      // Scenario D: random symbols right after reset (R2 R4 R6 R7)
      do_reset();
      cur_req = "R2 R4 R6 R7";
      for (int i = 0; i < 500; i++) send(2'($urandom), 1'b0, 1'b0, $urandom % 2);
      idle(3);
      check(exp_q.size() == 0, "R7", "pending outputs after noisy run", exp_q.size(), 0);
      check(out_count == 486, "R7", "outputs count noisy run", out_count, 486);

      // Scenario E: reset in the middle of a stream (R9)
      do_reset();
      cur_req = "R9";
      for (int i = 0; i < 20; i++) send_info(1'($urandom), 2'b00, 0);
      do_reset();
      for (int i = 0; i < L - 1; i++) send_info(1'($urandom), 2'b00, 0);
      idle(2);
      check(out_count == 0, "R9", "outputs before refill", out_count, 0);
      for (int i = 0; i < 30; i++) send_info(1'($urandom), 2'b00, 0);
      idle(3);
      check(out_count == 30, "R9", "outputs after refill", out_count, 30);
      check(exp_q.size() == 0, "R9", "pending outputs after refill", exp_q.size(), 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule